// File: doc/BRIEF.md
# Unstoppable Watchdog Timer with Keyed Service

This block is a watchdog timer on a 16-bit register port. It counts edges of a slow timebase, near 32 kHz, that runs beside the bus clock. Software sets a timeout in half-second steps and enables the timer. After that, software must keep reloading the timer by writing a two-word key to the service register. If the count runs out first, the block raises a reset request. It can also pull an active-low external watchdog line, and it records that the last reset came from a timeout.

Once enabled, the timer cannot be stopped. The low-power pause bit can be written only once after reset. A software reset request is also available.

A separate power-down counter runs from reset. It pulls the external line low once, unless software disarms it first.

Top module: `wdt_timer`

## Requirements
- R1: The register map uses byte offsets: control at 0x0, service at 0x2, status at 0x4 and misc at 0x8. Control reads back as {timeout[15:8], 3'b000, 1'b1, rst_en[3], enable[2], 1'b0, lp_pause[0]}. Status reads {14'b0, timeout_flag[1], 1'b0}. Misc reads {15'b0, pd_arm[0]}. The service register and all other offsets read 0.
- R2: A rising edge of the timebase is counted once. The block counts time in ticks of HALF_TICKS timebase edges each. Enabling the timer, or completing a service, loads the timeout field N. The reset request then rises after exactly (N+1)*HALF_TICKS further ticks, unless the timer is reloaded first.
- R3: Control bit 2 enables the timer. Once it is set, a later control write with bit 2 at 0 leaves it set.
- R4: A service write of 0x5555 followed by a service write of 0xAAAA reloads the counter from the timeout field. Any other service write after 0x5555 cancels the sequence. A write of 0xAAAA that is not armed by 0x5555 is ignored. A reload in the same cycle as a tick takes precedence over it.
- R5: The timeout field can be rewritten while the timer runs. The new value is used only from the next load, service reload or expiry.
- R6: Control bit 0 is taken only from the first control write after reset; later writes leave it unchanged. While the bit is 1 and lowpwr_i is high, counting pauses.
- R7: On expiry, rst_o goes high from the expiry tick until the next tick, and the counter reloads. While control bit 3 is 1, wdog_n_o is low over the same interval.
- R8: An expiry sets status bit 1. The bit survives rst_n_i and is cleared only by por_n_i.
- R9: A control write with bit 4 at 0 sets rst_o high until the next tick, without touching the counter.
- R10: A power-down counter starts at reset. At the PD_TICKS-th tick it drives wdog_n_o low until the next tick, unless misc bit 0 has been cleared by writing it as 0 before that tick. Writing 1 to bit 0 does not re-arm it.
- R11: After reset, rst_o is 0 and wdog_n_o is 1. Control reads 0x0010, misc reads 0x0001 and status reads 0.
- R12: The timebase input passes through a two-stage synchronizer. A rising edge that the bus clock samples at edge j is counted at edge j+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous assert, released synchronously |
| rst_n_i | input | 1 | System reset, active low; keeps the timeout flag |
| slow_clk_i | input | 1 | Slow timebase, asynchronous to clk_i |
| lowpwr_i | input | 1 | Low-power mode indication |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register byte offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| rst_o | output | 1 | Reset request, active high |
| wdog_n_o | output | 1 | External watchdog line, active low |

## Verification
The bench builds the block with HALF_TICKS=4 and PD_TICKS=40, and toggles the timebase every three bus clocks. One tick then spans six clocks, and a full timeout period fits in tens to a few hundred cycles. This short period brings several behaviours within reach in one run: repeated expiries, missed and successful service windows, the power-down pulse and the pause under low power. A behavioural tick-count model predicts rst_o and wdog_n_o on every clock, including the two-edge synchronizer delay.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 16;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_SVC  = 4'h2;
  localparam logic [3:0] OFS_STAT = 4'h4;
  localparam logic [3:0] OFS_MISC = 4'h8;
  localparam int CB_PAUSE = 0;
  localparam int CB_EN    = 2;
  localparam int CB_RSTEN = 3;
  localparam int CB_SWREQ = 4;
  localparam logic [DW-1:0] KEY_ARM  = 16'h5555;
  localparam logic [DW-1:0] KEY_FIRE = 16'hAAAA;
endpackage

// File: rtl/wdt_tick_sync.sv
module wdt_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic slow_i,
  output logic tick_o
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;

  always_comb sh_d = {sh_q[STAGES-2:0], slow_i};

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign tick_o = sh_q[STAGES-1] & ~prev_q;

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    tick_o |=> !tick_o); // R12
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          exp_i,
  output logic [7:0]    fld_d_o,
  output logic          en_o,
  output logic          rsten_o,
  output logic          pause_o,
  output logic          load_o,
  output logic          sw_o,
  output logic          pd_arm_o
);
  logic [7:0] fld_q, fld_d;
  logic rsten_q, rsten_d, en_q, en_d, pause_q, pause_d, lock_q, lock_d;
  logic arm_q, arm_d, pd_q, pd_d, tout_q, tout_d;
  logic wr_ctrl, wr_svc, wr_misc, reload;

  assign wr_ctrl = we_i && (addr_i == AW'(OFS_CTRL));
  assign wr_svc  = we_i && (addr_i == AW'(OFS_SVC));
  assign wr_misc = we_i && (addr_i == AW'(OFS_MISC));

  always_comb begin
    fld_d   = wr_ctrl ? wdata_i[15:8] : fld_q;
    rsten_d = wr_ctrl ? wdata_i[CB_RSTEN] : rsten_q;
    en_d    = en_q | (wr_ctrl & wdata_i[CB_EN]);
    pause_d = (wr_ctrl && !lock_q) ? wdata_i[CB_PAUSE] : pause_q;
    lock_d  = lock_q | wr_ctrl;
    arm_d   = wr_svc ? (wdata_i == KEY_ARM) : arm_q;
    reload  = wr_svc && arm_q && (wdata_i == KEY_FIRE);
    pd_d    = pd_q & ~(wr_misc & ~wdata_i[0]);
    tout_d  = tout_q | exp_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      fld_q   <= '0;
      rsten_q <= 1'b0;
      en_q    <= 1'b0;
      pause_q <= 1'b0;
      lock_q  <= 1'b0;
      arm_q   <= 1'b0;
      pd_q    <= 1'b1;
    end else begin
      if (wr_ctrl) begin
        fld_q   <= fld_d;
        rsten_q <= rsten_d;
        en_q    <= en_d;
        pause_q <= pause_d;
        lock_q  <= lock_d;
      end
      if (wr_svc)  arm_q <= arm_d;
      if (wr_misc) pd_q  <= pd_d;
    end
  end

  always_ff @(posedge clk_i or negedge por_n) begin
    if (!por_n) tout_q <= 1'b0;
    else if (exp_i) tout_q <= tout_d;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(OFS_CTRL): rdata_o = {fld_q, 3'b000, 1'b1, rsten_q, en_q, 1'b0, pause_q};
      AW'(OFS_STAT): rdata_o = {14'b0, tout_q, 1'b0};
      AW'(OFS_MISC): rdata_o = {15'b0, pd_q};
      default:       rdata_o = '0;
    endcase
  end

  assign fld_d_o  = fld_d;
  assign en_o     = en_q;
  assign rsten_o  = rsten_q;
  assign pause_o  = pause_q;
  assign load_o   = (en_d & ~en_q) | reload;
  assign sw_o     = wr_ctrl & ~wdata_i[CB_SWREQ];
  assign pd_arm_o = pd_q;

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    en_q |=> en_q); // R3
  AST_PAUSE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_n)
    lock_q |=> $stable(pause_q)); // R6
  AST_PD_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_n)
    !pd_q |=> !pd_q); // R10
  AST_TOUT_SET: assert property (@(posedge clk_i) disable iff (!por_n)
    exp_i |=> tout_q); // R8
  AST_TOUT_KEEP: assert property (@(posedge clk_i) disable iff (!por_n)
    tout_q |=> tout_q); // R8
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int HALF_TICKS = 16384
) (
  input  logic       clk_i,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       load_i,
  input  logic [7:0] ld_val_i,
  output logic       exp_o
);
  localparam int PW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(HALF_TICKS - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [7:0]    hs_q, hs_d;
  logic          step, wrap;

  assign step  = tick_i & run_i & ~load_i;
  assign wrap  = (pre_q == PRE_LAST);
  assign exp_o = step & wrap & (hs_q == 8'd0);

  always_comb begin
    pre_d = pre_q;
    hs_d  = hs_q;
    if (load_i) begin
      pre_d = '0;
      hs_d  = ld_val_i;
    end else if (step) begin
      if (wrap) begin
        pre_d = '0;
        hs_d  = (hs_q == 8'd0) ? ld_val_i : hs_q - 8'd1;
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      hs_q  <= '0;
    end else if (load_i || step) begin
      pre_q <= pre_d;
      hs_q  <= hs_d;
    end
  end

  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run_i && !load_i) |=> ($stable(pre_q) && $stable(hs_q))); // R6
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_i |=> (pre_q == '0 && hs_q == $past(ld_val_i))); // R4
endmodule

// File: rtl/wdt_pdcnt.sv
module wdt_pdcnt #(
  parameter int PD_TICKS = 524288
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic tick_i,
  input  logic arm_i,
  output logic fire_o
);
  localparam int CW = (PD_TICKS > 1) ? $clog2(PD_TICKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PD_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d, last;

  assign last   = tick_i & ~done_q & (cnt_q == CNT_LAST);
  assign fire_o = last & arm_i;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q | last;
    if (tick_i && !done_q && !last) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  AST_PD_DONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_q |=> done_q); // R10
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int HALF_TICKS  = 16384,
  parameter int PD_TICKS    = 524288,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 4
) (
  input  logic          clk_i,
  input  logic          por_n_i,
  input  logic          rst_n_i,
  input  logic          slow_clk_i,
  input  logic          lowpwr_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [15:0]   bus_wdata_i,
  output logic [15:0]   bus_rdata_o,
  output logic          rst_o,
  output logic          wdog_n_o
);
  logic sys_n, tick, exp, load, sw, pd_fire, pd_arm;
  logic en, rsten, pause, run;
  logic [7:0] fld_d;
  logic exp_hold_q, exp_hold_d, sw_hold_q, sw_hold_d, pd_hold_q, pd_hold_d;

  assign sys_n = por_n_i & rst_n_i;

  wdt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_n(sys_n), .slow_i(slow_clk_i), .tick_o(tick));

  wdt_regs #(.AW(AW)) u_regs (
    .clk_i(clk_i), .rst_n(sys_n), .por_n(por_n_i),
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .exp_i(exp), .fld_d_o(fld_d), .en_o(en),
    .rsten_o(rsten), .pause_o(pause), .load_o(load), .sw_o(sw),
    .pd_arm_o(pd_arm));

  assign run = en & ~(pause & lowpwr_i);

  wdt_counter #(.HALF_TICKS(HALF_TICKS)) u_cnt (
    .clk_i(clk_i), .rst_n(sys_n), .tick_i(tick), .run_i(run),
    .load_i(load), .ld_val_i(fld_d), .exp_o(exp));

  wdt_pdcnt #(.PD_TICKS(PD_TICKS)) u_pd (
    .clk_i(clk_i), .rst_n(sys_n), .tick_i(tick), .arm_i(pd_arm),
    .fire_o(pd_fire));

  always_comb begin
    exp_hold_d = exp     ? 1'b1 : (tick ? 1'b0 : exp_hold_q);
    sw_hold_d  = sw      ? 1'b1 : (tick ? 1'b0 : sw_hold_q);
    pd_hold_d  = pd_fire ? 1'b1 : (tick ? 1'b0 : pd_hold_q);
  end

  always_ff @(posedge clk_i or negedge sys_n) begin
    if (!sys_n) begin
      exp_hold_q <= 1'b0;
      sw_hold_q  <= 1'b0;
      pd_hold_q  <= 1'b0;
    end else begin
      exp_hold_q <= exp_hold_d;
      sw_hold_q  <= sw_hold_d;
      pd_hold_q  <= pd_hold_d;
    end
  end

  assign rst_o    = exp_hold_q | sw_hold_q;
  assign wdog_n_o = ~((exp_hold_q & rsten) | pd_hold_q);

  AST_RST_CAUSE: assert property (@(posedge clk_i) disable iff (!sys_n)
    $rose(rst_o) |-> $past(exp | sw)); // R7
  AST_EXP_DROP: assert property (@(posedge clk_i) disable iff (!sys_n)
    (tick && !exp) |=> !exp_hold_q); // R7
  AST_SW_PULSE: assert property (@(posedge clk_i) disable iff (!sys_n)
    sw |=> rst_o); // R9
endmodule

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;
  localparam int H  = 4;
  localparam int PD = 40;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, slow = 1'b0, lp = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic rst_o, wdog_n;

  int checks = 0, errors = 0, rises = 0;
  string phase = "R11";
  logic prev_rst = 1'b0;

  wdt_timer #(.HALF_TICKS(H), .PD_TICKS(PD)) u_wdt_timer (
    .clk_i(clk), .por_n_i(por_n), .rst_n_i(rst_n), .slow_clk_i(slow),
    .lowpwr_i(lp), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .rst_o(rst_o), .wdog_n_o(wdog_n));

  always #10 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    slow = ~slow;
  end

  // behavioural model
  bit q[$];
  logic [7:0] m_fld;
  bit m_rsten, m_en, m_pause, m_lock, m_arm, m_pd, m_tout, m_pd_done;
  bit m_eh, m_sh, m_ph;
  int m_rem, m_pdc;

  task automatic m_sys_reset();
    q = {1'b0, 1'b0, 1'b0, 1'b0};
    m_fld = 8'h00; m_rsten = 0; m_en = 0; m_pause = 0; m_lock = 0; m_arm = 0;
    m_pd = 1; m_pd_done = 0; m_eh = 0; m_sh = 0; m_ph = 0; m_rem = 0; m_pdc = 0;
  endtask

  always @(posedge clk) begin
    if (!por_n) begin
      m_sys_reset();
      m_tout = 0;
    end else if (!rst_n) begin
      m_sys_reset();
    end else begin
      bit tk, o_en, o_pause, o_pd, ld, sw, ex, pf;
      q.push_front(slow);
      q = q[0:3];
      tk = q[2] && !q[3];
      o_en = m_en; o_pause = m_pause; o_pd = m_pd;
      ld = 0; sw = 0; ex = 0; pf = 0;
      if (we && addr == 4'h0) begin
        m_fld = wdata[15:8];
        m_rsten = wdata[3];
        if (wdata[2]) m_en = 1;
        if (!m_lock) m_pause = wdata[0];
        m_lock = 1;
        if (!o_en && m_en) ld = 1;
        sw = !wdata[4];
      end
      if (we && addr == 4'h2) begin
        if (m_arm && wdata == 16'hAAAA) ld = 1;
        m_arm = (wdata == 16'h5555);
      end
      if (we && addr == 4'h8 && !wdata[0]) m_pd = 0;
      if (ld) m_rem = (m_fld + 1) * H;
      else if (tk && o_en && !(o_pause && lp)) begin
        m_rem--;
        if (m_rem == 0) begin ex = 1; m_rem = (m_fld + 1) * H; end
      end
      if (tk && !m_pd_done) begin
        m_pdc++;
        if (m_pdc == PD) begin m_pd_done = 1; pf = o_pd; end
      end
      m_eh = ex ? 1 : (tk ? 0 : m_eh);
      m_sh = sw ? 1 : (tk ? 0 : m_sh);
      m_ph = pf ? 1 : (tk ? 0 : m_ph);
      if (ex) m_tout = 1;
    end
  end

  always @(posedge clk) begin
    if (rst_o && !prev_rst) rises++;
    prev_rst <= rst_o;
  end

  always @(negedge clk) begin
    #2;
    if (por_n && rst_n) begin
      bit e_rst, e_wn;
      e_rst = m_eh || m_sh;
      e_wn = !((m_eh && m_rsten) || m_ph);
      checks++;
      if (rst_o !== e_rst || wdog_n !== e_wn) begin
        errors++;
        $display("FAIL %s outputs: actual rst_o=%b wdog_n_o=%b expected rst_o=%b wdog_n_o=%b",
                 phase, rst_o, wdog_n, e_rst, e_wn);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    @(negedge clk); we = 0; addr = a;
    #4;
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s read 0x%0h: actual=0x%04h expected=0x%04h", tag, a, rdata, e);
    end
  endtask

  task automatic chk(input bit c, input int act, input int exp, input string tag);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    phase = "R11";
    chk(rst_o == 0 && wdog_n == 1, rst_o, 0, "R11 outputs after reset");
    rd(4'h0, 16'h0010, "R11 ctrl");
    rd(4'h8, 16'h0001, "R1 misc");
    rd(4'h4, 16'h0000, "R1 status");
    rd(4'h2, 16'h0000, "R1 service");
    phase = "R10";
    repeat (260) @(negedge clk);
    phase = "R2";
    wr(4'h0, 16'h021C);
    repeat (100) @(negedge clk);
    rd(4'h4, 16'h0002, "R8 status after expiry");
    rd(4'h0, 16'h021C, "R1 ctrl readback");
    phase = "R3";
    wr(4'h0, 16'h0219);
    rd(4'h0, 16'h021C, "R3 enable kept, R6 pause locked");
    phase = "R4";
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    base = rises;
    for (int i = 0; i < 8; i++) begin
      repeat (40) @(negedge clk);
      wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    end
    chk(rises == base, rises - base, 0, "R4 serviced timer stays quiet");
    base = rises;
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    wr(4'h2, 16'hAAAA);
    repeat (100) @(negedge clk);
    chk(rises > base, rises - base, 1, "R4 cancelled key does not reload");
    phase = "R5";
    wr(4'h0, 16'h051C);
    repeat (60) @(negedge clk);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    repeat (160) @(negedge clk);
    phase = "R9";
    wr(4'h0, 16'h050C);
    #3;
    chk(rst_o == 1, rst_o, 1, "R9 software reset request");
    phase = "R7";
    wr(4'h0, 16'h0514);
    repeat (160) @(negedge clk);
    phase = "R8";
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    rd(4'h4, 16'h0002, "R8 flag survives system reset");
    rd(4'h0, 16'h0010, "R8 ctrl cleared by system reset");
    @(negedge clk); por_n = 0;
    repeat (2) @(negedge clk); por_n = 1;
    rd(4'h4, 16'h0000, "R8 flag cleared by power-on reset");
    phase = "R6";
    wr(4'h8, 16'h0000);
    wr(4'h8, 16'h0001);
    rd(4'h8, 16'h0000, "R10 disarm is permanent");
    lp = 1;
    wr(4'h0, 16'h0115);
    rd(4'h0, 16'h0115, "R6 pause bit taken on first write");
    base = rises;
    repeat (300) @(negedge clk);
    chk(rises == base, rises - base, 0, "R6 paused in low power");
    lp = 0;
    repeat (80) @(negedge clk);
    chk(rises > base, rises - base, 1, "R6 counting resumes");
    phase = "R12";
    repeat (50) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule